// File: doc/BRIEF.md
# Fixed-Frame Serial Configuration Write Slave

This block is a write-only slave on a two-wire serial bus of the SMBus kind. It runs on a fast system clock, oversamples the bus clock and data lines through synchronisers, and recognises START and STOP conditions. Once a frame starts, it shifts in bytes most significant bit first and acknowledges each one by pulling the data line low for the ninth bus clock.

A frame always has the same layout. The first byte is the slave address, with the direction bit included. Two bytes follow that the slave accepts but does not interpret: a command byte and a count byte. They are present only so that the byte positions line up. The seven bytes after them are taken by position into seven 8-bit configuration registers. The registers drive a flat parallel output that steers the downstream logic.

If the address byte does not match the fixed pattern, the slave stays silent and ignores the line until the next START. No register is touched in that case. This lets other slaves share the bus.

Top module: `smbw_cfg_slave`

## Requirements
- R1: A frame is accepted only when its first byte, sampled as all eight bits including the direction bit, equals 8'hD2. On acceptance, the address byte is acknowledged: the slave pulls the data line low during the ninth bus clock.
- R2: When the first byte differs from 8'hD2, the slave acknowledges neither that byte nor any later byte of the frame. It never pulls the data line low and changes no register until a new START.
- R3: The second and third bytes of an accepted frame are acknowledged, and their values change no register.
- R4: In an accepted frame, byte position 4+k (counting the address as position 1) loads register k, for k from 0 to 6. Register k appears on `cfg_regs[8k+7:8k]`.
- R5: A data byte's register takes its new value when that byte's acknowledge begins, at the bus-clock falling edge that ends its eighth bit. The new value is visible before the ninth bus clock ends.
- R6: Bytes after the tenth byte of an accepted frame are acknowledged and change no register.
- R7: A STOP (data rising while the bus clock is high) or a repeated START (data falling while the bus clock is high) ends the current frame at any point. The next frame starts again at the address position. Registers written before the interruption keep their new values.
- R8: While `rst_n` is low at a clock edge, all seven registers are loaded with 8'hFF and the data line is released.
- R9: Data bits are sampled on bus-clock rising edges, with the first bit received placed in bit 7 of the byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line, asynchronous to `clk` |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous to `clk` |
| sda_drive_low | output | 1 | High when the slave pulls the data line low (open-drain acknowledge) |
| cfg_regs | output | 56 | Seven configuration registers; register k occupies bits 8k+7 down to 8k |

## Verification
The assertions check the following on every cycle:
- Registers stay constant outside a write strobe.
- Every write coincides with an acknowledge being driven.
- The acknowledge starts only on a bus-clock falling edge and lasts a single bus-clock period.
- The data line is released after a STOP.
- Reset loads all registers with ones.

Other behaviours depend on the content of whole frames, so only the bench scenarios can show them. These are:
- Address matching, including the direction bit.
- The positional mapping of data bytes to registers.
- The discarding of the command, count and surplus bytes.
- Partial register updates when a frame is cut short by a STOP or a repeated START.

// File: rtl/smbw_pkg.sv
// Package smbw_pkg
// Shared types for the fixed-frame configuration write slave.
// Assumes: bytes are 8 bits wide on the serial bus.
package smbw_pkg;

    typedef logic [7:0] byte_t;

    // Byte engine state: waiting for START, shifting data bits, driving acknowledge
    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_BITS = 2'd1,
        ENG_ACK  = 2'd2
    } eng_state_t;

endpackage

// File: rtl/smbw_sync.sv
// Module smbw_sync
// Multi-bit two-flop synchroniser bringing asynchronous bus lines into the
// clk domain. Each bit is independent; resets to the idle (high) bus level.
// Assumes: inputs change far slower than clk, so bits need no coherence.
module smbw_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First capture flop, exposed to metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '1;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                // Further resolution flops
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '1;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/smbw_cond_detect.sv
// Module smbw_cond_detect
// Turns synchronised bus clock and data levels into single-cycle events:
// bus-clock rising and falling edges, START and STOP conditions.
// Assumes: inputs are already synchronous to clk.
module smbw_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_lvl
);

    logic scl_q;
    logic sda_q;

    // Keep previous levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Edge and condition decoding
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
        sda_lvl   = sda_s;
    end

endmodule

// File: rtl/smbw_byte_engine.sv
// Module smbw_byte_engine
// Frame sequencer: shifts in bytes MSB first on bus-clock rising edges,
// checks the address byte, drives the acknowledge during the ninth clock,
// and issues a register write strobe for each data byte when its acknowledge
// begins. Header bytes after the address and bytes past the frame are
// acknowledged without a strobe. STOP or START resets the byte position.
// Assumes: single-cycle event inputs from smbw_cond_detect.
module smbw_byte_engine
    import smbw_pkg::*;
#(
    parameter int    NREG      = 7,
    parameter int    HDR_BYTES = 3,
    parameter byte_t ADDR      = 8'hD2,
    localparam int   FRAME     = HDR_BYTES + NREG,
    localparam int   POS_W     = $clog2(FRAME + 1),
    localparam int   IDX_W     = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             sda_lvl,
    output logic             ack_drive,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output byte_t            wr_data
);

    eng_state_t       state_q;
    byte_t            shift_q;
    logic [3:0]       bit_cnt_q;
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] data_off;
    logic             byte_full;
    logic             is_data_pos;
    logic             addr_ok;

    // Decode the position of the current byte within the frame
    always_comb begin
        byte_full   = (bit_cnt_q == 4'd8);
        is_data_pos = (pos_q >= POS_W'(HDR_BYTES)) && (pos_q < POS_W'(FRAME));
        data_off    = pos_q - POS_W'(HDR_BYTES);
        addr_ok     = (shift_q == ADDR);
    end

    // Frame sequencing, acknowledge drive and write strobe generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ENG_IDLE;
            shift_q   <= '0;
            bit_cnt_q <= '0;
            pos_q     <= '0;
            ack_drive <= 1'b0;
            wr_en     <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state_q   <= ENG_BITS;
                bit_cnt_q <= '0;
                pos_q     <= '0;
                ack_drive <= 1'b0;
            end else if (stop_det) begin
                state_q   <= ENG_IDLE;
                bit_cnt_q <= '0;
                pos_q     <= '0;
                ack_drive <= 1'b0;
            end else begin
                case (state_q)
                    ENG_BITS: begin
                        if (scl_rise && !byte_full) begin
                            shift_q   <= {shift_q[6:0], sda_lvl};
                            bit_cnt_q <= bit_cnt_q + 4'd1;
                        end else if (scl_fall && byte_full) begin
                            if ((pos_q == '0) && !addr_ok) begin
                                state_q <= ENG_IDLE;
                            end else begin
                                state_q   <= ENG_ACK;
                                ack_drive <= 1'b1;
                                if (is_data_pos) begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= IDX_W'(data_off);
                                    wr_data <= shift_q;
                                end
                            end
                        end
                    end
                    ENG_ACK: begin
                        if (scl_fall) begin
                            state_q   <= ENG_BITS;
                            ack_drive <= 1'b0;
                            bit_cnt_q <= '0;
                            if (pos_q < POS_W'(FRAME)) pos_q <= pos_q + 1'b1;
                        end
                    end
                    default: begin
                        ack_drive <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/smbw_reg_bank.sv
// Module smbw_reg_bank
// Bank of NREG byte-wide configuration registers with one write port,
// flattened onto a parallel output bus. Reset loads RST_VAL.
// Assumes: wr_idx is below NREG whenever wr_en is high.
module smbw_reg_bank
    import smbw_pkg::*;
#(
    parameter int    NREG    = 7,
    parameter byte_t RST_VAL = 8'hFF,
    localparam int   IDX_W   = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  byte_t             wr_data,
    output logic [NREG*8-1:0] regs_flat
);

    genvar k;
    generate
        for (k = 0; k < NREG; k++) begin : g_reg
            byte_t reg_q;
            // Hold register k, load on a matching write strobe
            always_ff @(posedge clk) begin
                if (!rst_n)                                reg_q <= RST_VAL;
                else if (wr_en && (wr_idx == IDX_W'(k)))   reg_q <= wr_data;
            end
            assign regs_flat[8*k +: 8] = reg_q;
        end
    endgenerate

endmodule

// File: rtl/smbw_cfg_slave.sv
// Module smbw_cfg_slave
// Top of the fixed-frame configuration write slave: synchroniser, bus
// condition detector, byte engine and register bank.
// Assumes: clk is at least about 8x the bus clock rate; the data line output
// is open-drain, sda_drive_low high meaning pull low.
module smbw_cfg_slave
    import smbw_pkg::*;
#(
    parameter int    NREG      = 7,
    parameter int    HDR_BYTES = 3,
    parameter byte_t ADDR      = 8'hD2,
    parameter byte_t RST_VAL   = 8'hFF,
    localparam int   IDX_W     = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_drive_low,
    output logic [NREG*8-1:0] cfg_regs
);

    logic [1:0]       bus_s;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic             sda_lvl;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    byte_t            wr_data;

    smbw_sync #(.WIDTH(2), .STAGES(2)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({scl_in, sda_in}),
        .sync_out (bus_s)
    );

    smbw_cond_detect i_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (bus_s[1]),
        .sda_s     (bus_s[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_lvl   (sda_lvl)
    );

    smbw_byte_engine #(.NREG(NREG), .HDR_BYTES(HDR_BYTES), .ADDR(ADDR)) i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_lvl   (sda_lvl),
        .ack_drive (sda_drive_low),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    smbw_reg_bank #(.NREG(NREG), .RST_VAL(RST_VAL)) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .regs_flat (cfg_regs)
    );

endmodule

// File: rtl/smbw_cfg_checker.sv
// Module smbw_cfg_checker
// Temporal properties for smbw_cfg_slave, attached by bind below.
// Assumes: sees the top's ports and the nets between its sub-blocks.
module smbw_cfg_checker #(
    parameter int REG_BITS = 56
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sda_drive_low,
    input logic [REG_BITS-1:0] cfg_regs,
    input logic                wr_en,
    input logic                scl_fall,
    input logic                stop_det
);

    // Reset loads every register with ones
    p_reset_ones_r8: assert property (@(posedge clk)
        !rst_n |=> (cfg_regs == {REG_BITS{1'b1}}));

    // Registers move only on a write strobe (ignored bytes change nothing)
    p_regs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_regs));

    // A register write happens only together with an acknowledge
    p_write_with_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sda_drive_low);

    // Acknowledge begins right after a bus-clock falling edge
    p_ack_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low) |-> $past(scl_fall));

    // Acknowledge lasts one bus clock: released at the next falling edge
    p_ack_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_drive_low && scl_fall) |=> !sda_drive_low);

    // STOP releases the data line
    p_stop_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_drive_low);

endmodule

bind smbw_cfg_slave smbw_cfg_checker #(.REG_BITS(NREG*8)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sda_drive_low (sda_drive_low),
    .cfg_regs      (cfg_regs),
    .wr_en         (wr_en),
    .scl_fall      (scl_fall),
    .stop_det      (stop_det)
);

// File: tb/test_smbw_cfg_slave.sv
// Bench for smbw_cfg_slave: bit-level bus master with open-drain data line,
// a register model, directed corner cases and seeded random frames.
module test_smbw_cfg_slave;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;      // clk cycles per bus phase
    localparam int NREG       = 7;
    localparam logic [7:0] MY_ADDR = 8'hD2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_tb = 1'b1;
    logic sda_tb = 1'b1;
    logic sda_drive_low;
    logic [NREG*8-1:0] cfg_regs;
    logic sda_line;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] exp_reg [NREG];
    logic [7:0] fr [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = sda_tb & ~sda_drive_low;

    smbw_cfg_slave i_smbw_cfg_slave (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl_tb),
        .sda_in        (sda_line),
        .sda_drive_low (sda_drive_low),
        .cfg_regs      (cfg_regs)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NREG*8-1:0] model_flat();
        logic [NREG*8-1:0] v;
        for (int k = 0; k < NREG; k++) v[8*k +: 8] = exp_reg[k];
        return v;
    endfunction

    function automatic bit ack_expected(input int pos, input logic [7:0] addr);
        return addr == MY_ADDR;
    endfunction

    task automatic bus_start();
        sda_tb = 1'b1; wait_cyc(HALF);
        scl_tb = 1'b1; wait_cyc(HALF);
        sda_tb = 1'b0; wait_cyc(HALF);
        scl_tb = 1'b0; wait_cyc(HALF);
    endtask

    task automatic bus_stop();
        sda_tb = 1'b0; wait_cyc(HALF);
        scl_tb = 1'b1; wait_cyc(HALF);
        sda_tb = 1'b1; wait_cyc(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_tb = b[i]; wait_cyc(HALF);
            scl_tb = 1'b1; wait_cyc(HALF);
            scl_tb = 1'b0; wait_cyc(HALF);
        end
        sda_tb = 1'b1; wait_cyc(HALF);
        scl_tb = 1'b1; wait_cyc(HALF/2);
        acked = (sda_line == 1'b0);
        wait_cyc(HALF - HALF/2);
        scl_tb = 1'b0; wait_cyc(HALF);
    endtask

    // Sends nbytes of fr[] after a START; checks acks and per-byte register effect
    task automatic run_frame(input int nbytes, input bit with_stop);
        bit ack;
        bit ok;
        string tag;
        ok = (fr[0] == MY_ADDR);
        bus_start();
        for (int p = 0; p < nbytes; p++) begin
            send_byte(fr[p], ack);
            if (p == 0)              tag = ok ? "R1 address ack" : "R2 address nack";
            else if (!ok)            tag = "R2 no ack after mismatch";
            else if (p < 3)          tag = "R3 header byte ack";
            else if (p < 3 + NREG)   tag = "R4 data byte ack";
            else                     tag = "R6 surplus byte ack";
            check(tag, 64'(ack), 64'(ack_expected(p, fr[0])));
            if (ok && p >= 3 && p < 3 + NREG) exp_reg[p-3] = fr[p];
            if (p >= 1) begin
                if (!ok)          tag = "R2 regs unchanged";
                else if (p < 3)   tag = "R3 header ignored";
                else if (p < 10)  tag = "R5 reg updated at ack";
                else              tag = "R6 surplus discarded";
                check(tag, 64'(cfg_regs), 64'(model_flat()));
            end
        end
        if (with_stop) bus_stop();
        check("R7 regs after frame end", 64'(cfg_regs), 64'(model_flat()));
    endtask

    initial begin
        bit ack;
        void'($urandom(32'h5EED1234));
        for (int k = 0; k < NREG; k++) exp_reg[k] = 8'hFF;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);

        // R8: reset state
        check("R8 regs reset", 64'(cfg_regs), 64'(model_flat()));
        check("R8 line released", 64'(sda_drive_low), 64'd0);

        // R1/R4/R9: full frame with distinct bit patterns
        fr[0] = MY_ADDR; fr[1] = 8'h5A; fr[2] = 8'h07;
        fr[3] = 8'h80; fr[4] = 8'h01; fr[5] = 8'h00; fr[6] = 8'hC3;
        fr[7] = 8'h3C; fr[8] = 8'hA5; fr[9] = 8'h12;
        run_frame(10, 1'b1);
        check("R9 MSB first reg0", 64'(cfg_regs[7:0]), 64'h80);
        check("R9 LSB last reg1", 64'(cfg_regs[15:8]), 64'h01);

        // R2: direction bit set (read address) is rejected
        fr[0] = 8'hD3;
        for (int p = 1; p < 10; p++) fr[p] = 8'h00;
        run_frame(10, 1'b1);
        check("R2 line idle after mismatch", 64'(sda_drive_low), 64'd0);

        // R7: STOP after data byte 2
        fr[0] = MY_ADDR; fr[1] = 8'hFF; fr[2] = 8'hFF;
        fr[3] = 8'h11; fr[4] = 8'h22; fr[5] = 8'h33;
        run_frame(6, 1'b1);
        check("R7 untouched reg3 keeps value", 64'(cfg_regs[31:24]), 64'hC3);

        // R7: repeated START mid-frame, next frame realigns at address
        fr[0] = MY_ADDR; fr[1] = 8'h00; fr[2] = 8'h00; fr[3] = 8'h44;
        run_frame(4, 1'b0);
        fr[0] = MY_ADDR; fr[1] = MY_ADDR; fr[2] = 8'h99; fr[3] = 8'h55; fr[4] = 8'h66;
        run_frame(5, 1'b1);
        check("R7 repeated start realign reg0", 64'(cfg_regs[7:0]), 64'h55);

        // R6: frame with surplus bytes
        fr[0] = MY_ADDR;
        for (int p = 1; p < 14; p++) fr[p] = 8'(p * 17);
        run_frame(14, 1'b1);

        // Seeded random frames
        for (int n = 0; n < 16; n++) begin
            fr[0] = ($urandom % 2 == 0) ? MY_ADDR : 8'($urandom);
            for (int p = 1; p < 16; p++) fr[p] = 8'($urandom);
            run_frame(1 + int'($urandom % 13), ($urandom % 4) != 0);
        end
        bus_stop();

        // R8: reset after activity
        rst_n = 1'b0; wait_cyc(2); rst_n = 1'b1; wait_cyc(1);
        for (int k = 0; k < NREG; k++) exp_reg[k] = 8'hFF;
        check("R8 regs reset again", 64'(cfg_regs), 64'(model_flat()));

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule